// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a synchronous serial link. Through it an external controller reads and writes a bank of 8-bit registers that sits behind a plain parallel port. The controller pulls the active-low select low and supplies exactly sixteen serial clocks. The first clock carries the transfer direction. The next six carry a register address. One clock is a spare slot whose value is discarded. The last eight clocks are the data phase. On a write, that phase delivers the new register value. On a read, the block shifts the addressed register back out on the same eight clocks.

All input bits are sampled on the rising serial clock edge and arrive most significant bit first. Read data changes on falling edges, so each bit is settled before the controller samples it on the following rising edge. The write strobe toward the register bank is raised only after the sixteenth bit has arrived. If select is released before that point, the frame is dropped without writing anything. Releasing select also clears the frame position. While select is high, the serial output floats.

Top module: `sreg_port`

## Requirements
- R1: The bit sampled on the first rising edge of a frame sets the direction: 1 selects a read and 0 selects a write.
- R2: The bits sampled on rising edges 2 to 7 form the 6-bit register address, most significant bit first. This address appears on `reg_addr` after rising edge 7 and holds steady for the remainder of the frame.
- R3: The bit sampled on rising edge 8 has no effect on the address, the data written, or the data read.
- R4: In a write frame, the bits sampled on rising edges 9 to 16 form the write data, most significant bit first. `reg_wdata` carries this value and `reg_wr` goes high at rising edge 16. The strobe drops at the next rising edge, or when select rises, whichever comes first.
- R5: In a read frame, `reg_rdata` is captured at the falling edge that follows rising edge 8. Its bits then drive `sdo` from bit 7 down to bit 0, one per falling edge, so that rising edges 9 to 16 see bit 7 through bit 0.
- R6: When `cs_n` is high, `sdo` is high-impedance. When `cs_n` is low and no read data phase is in progress, `sdo` drives 0.
- R7: If `cs_n` rises before rising edge 16, no write strobe is issued and the register bank keeps its contents.
- R8: When `cs_n` rises, the frame position returns to the start, so the next frame decodes correctly even after an aborted one.
- R9: Serial clocks after the sixteenth within a single select period produce no further write strobe.
- R10: A read frame never raises `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low select; when high it clears the frame position |
| sdi | input | 1 | Serial data from the controller, sampled on rising edges |
| sdo | output | 1 | Serial read data, changes on falling edges, floats when deselected |
| reg_addr | output | 6 | Register address decoded from the frame |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_wr | output | 1 | Write strobe, raised after a complete write frame |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
The bench targets the two edges of the write window. It aborts frames after 12 clocks and again after 15 clocks. A design whose strobe is tied to an early count would corrupt the register on those aborts. It also runs an 18-clock frame, which a design without a saturating counter would write twice or wrap. Read frames are run at both address extremes and with the spare bit set to 1. A design that loaded read data one edge late, or shifted the spare bit into the address, would return a rotated or misaddressed byte. Finally, the serial output is checked to be floating while deselected and driving 0 during write frames.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W_DEF = 6;
  localparam int DATA_W_DEF = 8;

  // direction slot + address + spare slot + data
  function automatic int frame_len(input int aw, input int dw);
    return 1 + aw + 1 + dw;
  endfunction

  // counter value (rising edges already seen) when the last address bit is on sdi
  function automatic int addr_last_cnt(input int aw);
    return aw;
  endfunction

  // counter value at the falling edge just before the first data-phase sample
  function automatic int load_cnt(input int aw);
    return aw + 2;
  endfunction

  function automatic int cnt_width(input int aw, input int dw);
    return $clog2(frame_len(aw, dw) + 1);
  endfunction
endpackage

// File: rtl/sreg_bitcnt.sv
module sreg_bitcnt #(
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input  logic             sclk,
  input  logic             cs_n,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);

  // counts rising edges in the frame, saturates at a full frame
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n)             cnt <= '0;
    else if (cnt != FULL) cnt <= cnt + 1'b1;
  end

  p_cnt_step_r8: assert property (@(posedge sclk) disable iff (cs_n)
    (cnt != FULL) |=> ((cnt - $past(cnt)) == CNT_W'(1)));

  p_cnt_hold_r9: assert property (@(posedge sclk) disable iff (cs_n)
    (cnt == FULL) |=> (cnt == FULL));
endmodule

// File: rtl/sreg_capture.sv
module sreg_capture #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [CNT_W-1:0]  cnt,
  output logic              rw_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q
);
  import sreg_pkg::*;
  localparam int FRAME_LEN = frame_len(ADDR_W, DATA_W);
  localparam int SH_W      = FRAME_LEN - 1;
  localparam logic [CNT_W-1:0] C_FIRST = '0;
  localparam logic [CNT_W-1:0] C_ADDR  = CNT_W'(addr_last_cnt(ADDR_W));
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(FRAME_LEN);

  logic [SH_W-1:0] sh;

  // named frame events
  logic dir_slot, addr_done, frame_done;
  assign dir_slot   = (cnt == C_FIRST);
  assign addr_done  = (cnt == C_ADDR);
  assign frame_done = (cnt == C_LAST);

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sh   <= '0;
      rw_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (cnt < C_FULL) sh <= {sh[SH_W-2:0], sdi};
      if (dir_slot)     rw_q <= sdi;
      if (frame_done)   wr_q <= ~rw_q;
    end
  end

  // address and write data hold their value across frames
  always_ff @(posedge sclk) begin
    if (!cs_n && addr_done)           addr_q  <= {sh[ADDR_W-2:0], sdi};
    if (!cs_n && frame_done && !rw_q) wdata_q <= {sh[DATA_W-2:0], sdi};
  end

  p_wr_full_frame_r7: assert property (@(posedge sclk) disable iff (cs_n)
    wr_q |-> (cnt == C_FULL));

  p_wr_pulse_r4: assert property (@(posedge sclk) disable iff (cs_n)
    wr_q |=> !wr_q);

  p_addr_hold_r2: assert property (@(posedge sclk) disable iff (cs_n)
    (cnt > C_ADDR) |=> $stable(addr_q));

  p_read_no_wr_r10: assert property (@(posedge sclk) disable iff (cs_n)
    ((cnt > C_FIRST) && rw_q) |-> !wr_q);
endmodule

// File: rtl/sreg_readout.sv
module sreg_readout #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rw_q,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo_bit
);
  import sreg_pkg::*;
  localparam logic [CNT_W-1:0] C_LOAD = CNT_W'(load_cnt(ADDR_W));

  logic [DATA_W-1:0] osr;
  logic              load_ev;
  assign load_ev = rw_q && (cnt == C_LOAD);

  // falling-edge shifter: output bits settle half a clock before sampling
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n)             osr <= '0;
    else if (load_ev)     osr <= rdata;
    else if (cnt > C_LOAD) osr <= {osr[DATA_W-2:0], 1'b0};
  end

  assign sdo_bit = osr[DATA_W-1];

  p_load_r5: assert property (@(posedge sclk) disable iff (cs_n)
    load_ev |-> (osr == rdata));

  p_quiet_write_r6: assert property (@(posedge sclk) disable iff (cs_n)
    !rw_q |-> !sdo_bit);
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
  parameter int ADDR_W = sreg_pkg::ADDR_W_DEF,
  parameter int DATA_W = sreg_pkg::DATA_W_DEF
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  input  logic [DATA_W-1:0] reg_rdata
);
  import sreg_pkg::*;
  localparam int FRAME_LEN = frame_len(ADDR_W, DATA_W);
  localparam int CNT_W     = cnt_width(ADDR_W, DATA_W);

  logic [CNT_W-1:0] cnt;
  logic             rw_q;
  logic             sdo_bit;

  sreg_bitcnt #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .sclk (sclk),
    .cs_n (cs_n),
    .cnt  (cnt)
  );

  sreg_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .sclk    (sclk),
    .cs_n    (cs_n),
    .sdi     (sdi),
    .cnt     (cnt),
    .rw_q    (rw_q),
    .addr_q  (reg_addr),
    .wdata_q (reg_wdata),
    .wr_q    (reg_wr)
  );

  sreg_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
    .sclk    (sclk),
    .cs_n    (cs_n),
    .cnt     (cnt),
    .rw_q    (rw_q),
    .rdata   (reg_rdata),
    .sdo_bit (sdo_bit)
  );

  assign sdo = cs_n ? 1'bz : sdo_bit;
endmodule

// File: tb/sreg_port_tb_top.sv
module sreg_port_tb_top;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b0;
  logic       sdi  = 1'b0;
  wire        sdo;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr;
  logic [7:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  mem    [64];
  logic [7:0]  shadow [64];
  logic [7:0]  exp_r[$];
  logic [13:0] exp_w[$];
  int          wr_seen = 0;
  int          wr_exp  = 0;

  sreg_port dut_i (
    .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata)
  );

  always #2 sclk = ~sclk;   // 250 MHz

  assign reg_rdata = mem[reg_addr];

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write monitor: every strobe must match a queued write (R4, R7, R9, R10)
  always @(posedge reg_wr) begin
    #1;
    wr_seen++;
    if (exp_w.size() == 0) begin
      check(1'b0, "R7/R9/R10 unexpected write", {2'b0, reg_addr, reg_wdata}, 16'h0);
    end else begin
      logic [13:0] e;
      e = exp_w.pop_front();
      check({reg_addr, reg_wdata} == e, "R4 write addr/data", {2'b0, reg_addr, reg_wdata}, {2'b0, e});
    end
    mem[reg_addr] = reg_wdata;
  end

  // read monitor: rebuilds the frame from the wires, compares read bytes (R1, R5)
  int         mon_cnt = 0;
  logic       mon_rw  = 1'b0;
  logic [7:0] mon_byte = 8'h0;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      mon_cnt = 0;
    end else begin
      mon_cnt++;
      if (mon_cnt == 1) mon_rw = sdi;
      if (mon_cnt >= 9 && mon_cnt <= 16) mon_byte = {mon_byte[6:0], sdo};
      if (mon_cnt == 16 && mon_rw) begin
        if (exp_r.size() == 0) begin
          check(1'b0, "R5 read with no expectation", {8'h0, mon_byte}, 16'h0);
        end else begin
          logic [7:0] e;
          e = exp_r.pop_front();
          check(mon_byte == e, "R1/R5 read data", {8'h0, mon_byte}, {8'h0, e});
        end
      end
    end
  end

  // driver: one frame of nclk clocks, pushes what the scoreboard should see
  task automatic frame(input bit rw, input logic [5:0] a, input logic [7:0] d,
                       input bit dmy, input int nclk);
    logic [15:0] bits;
    bits = {rw, a, dmy, d};
    if (nclk >= 16) begin
      if (rw) exp_r.push_back(shadow[a]);
      else begin
        exp_w.push_back({a, d});
        shadow[a] = d;
        wr_exp++;
      end
    end
    @(negedge sclk);
    cs_n = 1'b0;
    for (int k = 0; k < nclk; k++) begin
      if (k > 0) @(negedge sclk);
      sdi = (k < 16) ? bits[15-k] : 1'b1;
      #1;
      if (!rw && k >= 8 && k < 16)
        check(sdo === 1'b0, "R6 sdo low during write frame", {15'h0, sdo}, 16'h0);
    end
    @(negedge sclk);
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (2) @(negedge sclk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    #1 cs_n = 1'b1;   // deselect clears the block
    #2;
    check(sdo === 1'bz, "R6 sdo floats when deselected", {15'h0, sdo}, 16'h0);
    check(reg_wr === 1'b0, "R4 no strobe out of reset", {15'h0, reg_wr}, 16'h0);

    // writes (R1 direction 0, R2 address extremes, R3 spare bit 1, R4)
    frame(1'b0, 6'h00, 8'hA5, 1'b0, 16);
    frame(1'b0, 6'h3F, 8'h3C, 1'b1, 16);
    frame(1'b0, 6'h2A, 8'h81, 1'b0, 16);
    frame(1'b0, 6'h15, 8'hFF, 1'b1, 16);
    frame(1'b0, 6'h16, 8'h00, 1'b0, 16);
    check(sdo === 1'bz, "R6 sdo floats between frames", {15'h0, sdo}, 16'h0);

    // reads (R1 direction 1, R3 spare bit either value, R5, R10)
    frame(1'b1, 6'h00, 8'h00, 1'b1, 16);
    frame(1'b1, 6'h3F, 8'h00, 1'b0, 16);
    frame(1'b1, 6'h2A, 8'h00, 1'b1, 16);
    frame(1'b1, 6'h15, 8'h00, 1'b0, 16);
    frame(1'b1, 6'h16, 8'h00, 1'b1, 16);
    frame(1'b1, 6'h05, 8'h00, 1'b0, 16);
    check(wr_seen == wr_exp, "R10 read frames wrote nothing", 16'(wr_seen), 16'(wr_exp));

    // aborted writes (R7), then fresh frames decode correctly (R8)
    frame(1'b0, 6'h2A, 8'h11, 1'b0, 12);
    check(reg_wr === 1'b0, "R7 no strobe after 12-clock abort", {15'h0, reg_wr}, 16'h0);
    frame(1'b0, 6'h15, 8'h22, 1'b0, 15);
    check(reg_wr === 1'b0, "R7 no strobe after 15-clock abort", {15'h0, reg_wr}, 16'h0);
    check(wr_seen == wr_exp, "R7 abort count", 16'(wr_seen), 16'(wr_exp));
    frame(1'b1, 6'h2A, 8'h00, 1'b0, 16);
    frame(1'b1, 6'h15, 8'h00, 1'b0, 16);
    frame(1'b0, 6'h09, 8'h6E, 1'b1, 16);   // R8 write right after aborts
    frame(1'b1, 6'h09, 8'h00, 1'b0, 16);

    // overlong frame: one write only (R9)
    frame(1'b0, 6'h07, 8'h5A, 1'b0, 18);
    check(wr_seen == wr_exp, "R9 one strobe for 18 clocks", 16'(wr_seen), 16'(wr_exp));
    frame(1'b1, 6'h07, 8'h00, 1'b0, 18);
    frame(1'b1, 6'h3F, 8'h00, 1'b1, 16);

    repeat (4) @(negedge sclk);
    check(exp_r.size() == 0, "R5 all reads observed", 16'(exp_r.size()), 16'h0);
    check(exp_w.size() == 0, "R4 all writes observed", 16'(exp_w.size()), 16'h0);
    check(wr_seen == wr_exp, "R7/R9 total strobes", 16'(wr_seen), 16'(wr_exp));
    finish_run();
  end
endmodule